// File: doc/BRIEF.md
# Programmable Channel Clock Divider

The block derives an output clock from an input clock by alternating between a low phase and a high phase. Each phase length is programmed on its own as a 4-bit count of input cycles, encoded as length minus one. The ratio is therefore (low field + 1) + (high field + 1), which gives any ratio from 2 to 32, and uneven duty cycles follow from unequal fields.

A chip-level SYNC pulse restarts many such dividers together. While SYNC is obeyed, the output sits at a selectable start level. After SYNC is released, a programmable phase offset delays the first count, so that sibling channels can be staggered by whole input cycles. Other settings can hold the output at a static level or hand the input clock straight to the output.

New phase lengths are captured only at a restart or at a phase boundary, so a write that arrives in the middle of a phase cannot produce a runt pulse.

Top module: `chan_clk_div`

## Requirements
- R1: In steady running, a high phase lasts hi_cycles+1 input cycles and a low phase lasts lo_cycles+1 input cycles, for every combination of the two 4-bit fields; no phase exceeds 16 counted cycles.
- R2: While rst_n is low, clk_out is at the start_hi level. Release of reset then behaves exactly like release of an obeyed SYNC, so the default fields lo=1, hi=1 give a divide-by-4 output.
- R3: While sync is high and ign_sync is low, clk_out is held at the start_hi level (1 = high, 0 = low) from the next rising edge on.
- R4: After sync falls, counting from the first rising edge at which sync is sampled low, clk_out first changes on edge number phase_ofs + F + 1. F is hi_cycles when start_hi=1 and lo_cycles when start_hi=0.
- R5: With ign_sync=1, a high level on sync has no effect on the phase lengths.
- R6: With force_lvl=1, ign_sync=1 and bypass=0, clk_out is driven statically to the start_hi level (low while start_hi=0).
- R7: With ign_sync=0, force_lvl has no effect and the divider keeps toggling.
- R8: With bypass=1, clk_out equals clk_in, whatever force_lvl and ign_sync are.
- R9: A change of lo_cycles or hi_cycles made during a phase leaves that phase at its old length. The new lengths apply from the next phase boundary.
- R10: While bypass=1, the counter does not advance. When bypass returns to 0, clk_out resumes at the level it had before, and the interrupted phase completes its remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Chip-level restart request, active high |
| lo_cycles | input | 4 | Low phase length minus one |
| hi_cycles | input | 4 | High phase length minus one |
| bypass | input | 1 | 1 routes clk_in to clk_out and idles the counter |
| ign_sync | input | 1 | 1 makes the divider disregard sync |
| force_lvl | input | 1 | 1 (with ign_sync) holds clk_out at the start_hi level |
| start_hi | input | 1 | Level at restart: 1 high, 0 low |
| phase_ofs | input | 4 | Input cycles waited after restart before counting |
| clk_out | output | 1 | Divided, forced or passed-through clock |

## Verification
The divided output comes from a register, so it moves one rising edge after the step that ends a phase. The bench samples it at every falling edge and measures each phase as a count of falling-edge samples. For R4 the count starts at the falling edge where sync is dropped, which makes the expected count phase_ofs + F + 1.

Force and bypass act through combinational selection. A force setting made at one falling edge is checked at the next falling edge. In bypass, clk_out is sampled a quarter period after each clock edge so that it never races clk_in. For R10, the count that remains once bypass clears is the phase length minus the steps already taken before bypass was entered.

// File: rtl/chan_div_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions for the channel clock divider.
// Assumes: consumers take the default width from here unless overridden.
package chan_div_pkg;
    localparam int DEF_CNT_W = 4;

    // Source selected for the channel output.
    typedef enum logic [1:0] {
        SRC_DIV   = 2'd0,
        SRC_FORCE = 2'd1,
        SRC_THRU  = 2'd2
    } out_src_e;
endpackage

// File: rtl/cdv_sync_ctrl.sv
`timescale 1ns/1ps
// Module: cdv_sync_ctrl
// Decides when the phase counter may take a step. An obeyed sync (or reset)
// reloads the offset wait counter; after release the wait drains one input
// cycle at a time, then stepping is allowed. Bypass freezes the wait.
// Assumes: sync is synchronous to clk_in.
module cdv_sync_ctrl #(
    parameter int CNT_W = chan_div_pkg::DEF_CNT_W
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             ign_sync,
    input  logic             bypass,
    input  logic [CNT_W-1:0] phase_ofs,
    output logic             restart,
    output logic             run_step
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] wait_q;

    assign restart  = sync & ~ign_sync;
    assign run_step = rst_n & ~restart & ~bypass & (wait_q == '0);

    // Offset wait counter: load on restart, drain while not bypassed.
    always_ff @(posedge clk_in) begin
        if (!rst_n || restart) begin
            wait_q <= phase_ofs;
        end else if (!bypass && (wait_q != '0)) begin
            wait_q <= wait_q - ONE;
        end
    end
endmodule

// File: rtl/cdv_phase_cnt.sv
`timescale 1ns/1ps
// Module: cdv_phase_cnt
// Counts input cycles within the current phase and flips the level when the
// phase field is reached. The phase fields are captured on restart and at
// every phase boundary, so a phase never changes length once started.
// Assumes: run_step is low during restart.
module cdv_phase_cnt #(
    parameter int CNT_W = chan_div_pkg::DEF_CNT_W
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run_step,
    input  logic [CNT_W-1:0] lo_cycles,
    input  logic [CNT_W-1:0] hi_cycles,
    input  logic             start_hi,
    output logic             out_lvl
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] lo_q, hi_q, cnt_q;
    logic             lvl_q;
    logic [CNT_W-1:0] cur_field;
    logic             at_end;

    // Length field of the phase in progress.
    always_comb begin
        cur_field = lvl_q ? hi_q : lo_q;
        at_end    = (cnt_q == cur_field);
    end

    // Phase counter, level register and boundary capture of the fields.
    always_ff @(posedge clk_in) begin
        if (!rst_n || restart) begin
            lvl_q <= start_hi;
            cnt_q <= '0;
            lo_q  <= lo_cycles;
            hi_q  <= hi_cycles;
        end else if (run_step) begin
            if (at_end) begin
                lvl_q <= ~lvl_q;
                cnt_q <= '0;
                lo_q  <= lo_cycles;
                hi_q  <= hi_cycles;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign out_lvl = lvl_q;
endmodule

// File: rtl/cdv_out_sel.sv
`timescale 1ns/1ps
// Module: cdv_out_sel
// Chooses the output source: pass-through has priority, then the static
// forced level (only when sync is ignored), otherwise the divided level.
// Assumes: control inputs change away from clk_in edges.
module cdv_out_sel (
    input  logic clk_in,
    input  logic bypass,
    input  logic force_lvl,
    input  logic ign_sync,
    input  logic start_hi,
    input  logic out_lvl,
    output logic clk_out
);
    import chan_div_pkg::*;

    out_src_e src;

    // Source priority decode.
    always_comb begin
        if (bypass) begin
            src = SRC_THRU;
        end else if (force_lvl && ign_sync) begin
            src = SRC_FORCE;
        end else begin
            src = SRC_DIV;
        end
    end

    // Output multiplexer.
    always_comb begin
        case (src)
            SRC_THRU:  clk_out = clk_in;
            SRC_FORCE: clk_out = start_hi;
            default:   clk_out = out_lvl;
        endcase
    end
endmodule

// File: rtl/chan_clk_div.sv
`timescale 1ns/1ps
// Module: chan_clk_div
// Programmable channel clock divider with separate high/low lengths,
// sync restart with phase offset, static force and pass-through.
// Assumes: all inputs are synchronous to clk_in; reset is synchronous.
module chan_clk_div #(
    parameter int CNT_W = chan_div_pkg::DEF_CNT_W
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [CNT_W-1:0] lo_cycles,
    input  logic [CNT_W-1:0] hi_cycles,
    input  logic             bypass,
    input  logic             ign_sync,
    input  logic             force_lvl,
    input  logic             start_hi,
    input  logic [CNT_W-1:0] phase_ofs,
    output logic             clk_out
);
    logic restart;
    logic run_step;
    logic out_lvl;

    cdv_sync_ctrl #(.CNT_W(CNT_W)) u_sync (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .sync      (sync),
        .ign_sync  (ign_sync),
        .bypass    (bypass),
        .phase_ofs (phase_ofs),
        .restart   (restart),
        .run_step  (run_step)
    );

    cdv_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .restart   (restart),
        .run_step  (run_step),
        .lo_cycles (lo_cycles),
        .hi_cycles (hi_cycles),
        .start_hi  (start_hi),
        .out_lvl   (out_lvl)
    );

    cdv_out_sel u_sel (
        .clk_in    (clk_in),
        .bypass    (bypass),
        .force_lvl (force_lvl),
        .ign_sync  (ign_sync),
        .start_hi  (start_hi),
        .out_lvl   (out_lvl),
        .clk_out   (clk_out)
    );
endmodule

// File: rtl/chan_clk_div_chk.sv
`timescale 1ns/1ps
// Module: chan_clk_div_chk
// Property checker bound into chan_clk_div. Tracks the steps taken in the
// current phase on its own to bound phase length.
// Assumes: bound with the internal restart, run_step and out_lvl nets.
module chan_clk_div_chk #(
    parameter int CNT_W = chan_div_pkg::DEF_CNT_W
) (
    input logic clk_in,
    input logic rst_n,
    input logic sync,
    input logic ign_sync,
    input logic bypass,
    input logic force_lvl,
    input logic start_hi,
    input logic restart,
    input logic run_step,
    input logic out_lvl,
    input logic clk_out
);
    logic           lvl_d;
    logic [CNT_W:0] steps_q;
    logic [CNT_W:0] steps_before;

    // Steps already counted in the current level before this edge.
    always_comb begin
        steps_before = (out_lvl != lvl_d) ? '0 : steps_q;
    end

    // Phase step tracker.
    always_ff @(posedge clk_in) begin
        if (!rst_n || restart) begin
            lvl_d   <= out_lvl;
            steps_q <= '0;
        end else begin
            lvl_d   <= out_lvl;
            steps_q <= steps_before + {{CNT_W{1'b0}}, run_step};
        end
    end

    p_hold_start_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (sync && !ign_sync) |=> (out_lvl == $past(start_hi)));

    p_bypass_idle_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
        (bypass && !(sync && !ign_sync)) |=> $stable(out_lvl));

    p_force_level_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        (force_lvl && ign_sync && !bypass) |-> (clk_out == start_hi));

    p_no_overflow_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
        run_step |-> (steps_before[CNT_W] == 1'b0));
endmodule

bind chan_clk_div chan_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .sync      (sync),
    .ign_sync  (ign_sync),
    .bypass    (bypass),
    .force_lvl (force_lvl),
    .start_hi  (start_hi),
    .restart   (restart),
    .run_step  (run_step),
    .out_lvl   (out_lvl),
    .clk_out   (clk_out)
);

// File: tb/tb_chan_clk_div.sv
`timescale 1ns/1ps
module tb_chan_clk_div;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // Packed vector: [15:12] lo, [11:8] hi, [7:4] offset, [0] start_hi.
    localparam logic [15:0] VEC [NVEC] = '{
        16'h1100, 16'h0000, 16'hFF00, 16'h0F01, 16'hF001, 16'h2350,
        16'h5231, 16'h11F0, 16'h73A1, 16'h0041, 16'hE1C0, 16'h3381
    };

    logic       clk_in = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic [3:0] lo_cycles = 4'd1;
    logic [3:0] hi_cycles = 4'd1;
    logic       bypass = 1'b0;
    logic       ign_sync = 1'b0;
    logic       force_lvl = 1'b0;
    logic       start_hi = 1'b0;
    logic [3:0] phase_ofs = 4'd0;
    logic       clk_out;

    int n_chk = 0;
    int n_fail = 0;

    chan_clk_div dut (
        .clk_in(clk_in), .rst_n(rst_n), .sync(sync),
        .lo_cycles(lo_cycles), .hi_cycles(hi_cycles), .bypass(bypass),
        .ign_sync(ign_sync), .force_lvl(force_lvl), .start_hi(start_hi),
        .phase_ofs(phase_ofs), .clk_out(clk_out)
    );

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count falling-edge samples, starting now, while clk_out equals lvl.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (clk_out === lvl && n < 200) begin
            n++;
            @(negedge clk_in);
        end
    endtask

    // Apply fields, pulse an obeyed sync, return at the release falling edge.
    task automatic do_sync(input logic [3:0] lo, input logic [3:0] hi,
                           input logic [3:0] ofs, input logic st);
        @(negedge clk_in);
        lo_cycles = lo; hi_cycles = hi; phase_ofs = ofs; start_hi = st;
        ign_sync = 1'b0; force_lvl = 1'b0; bypass = 1'b0; sync = 1'b1;
        repeat (3) @(negedge clk_in);
        sync = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        // R2: reset level follows start_hi, then release acts like sync.
        repeat (3) @(negedge clk_in);
        chk("R2 reset level low", int'(clk_out), 0);
        start_hi = 1'b1;
        @(negedge clk_in); @(negedge clk_in);
        chk("R2 reset level high", int'(clk_out), 1);
        start_hi = 1'b0;
        @(negedge clk_in); @(negedge clk_in);
        rst_n = 1'b1;
        run_len(1'b0, n); chk("R2 first low after reset", n, 2);
        run_len(1'b1, n); chk("R2 default high", n, 2);
        run_len(1'b0, n); chk("R2 default low", n, 2);

        // Table: R4 first transition and R1 widths for mixed settings.
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] lo, hi, ofs, fs, os;
            logic st;
            lo = VEC[i][15:12]; hi = VEC[i][11:8]; ofs = VEC[i][7:4]; st = VEC[i][0];
            fs = st ? hi : lo; os = st ? lo : hi;
            do_sync(lo, hi, ofs, st);
            run_len(st, n);  chk("R4 first edge after sync", n, int'(ofs) + int'(fs) + 1);
            run_len(~st, n); chk("R1 second phase width", n, int'(os) + 1);
            run_len(st, n);  chk("R1 third phase width", n, int'(fs) + 1);
        end

        // R1: every low/high combination.
        for (int l = 0; l < 16; l++) begin
            for (int h = 0; h < 16; h++) begin
                do_sync(4'(l), 4'(h), 4'd0, 1'b0);
                run_len(1'b0, n); chk("R1 first low", n, l + 1);
                run_len(1'b1, n); chk("R1 high width", n, h + 1);
                run_len(1'b0, n); chk("R1 low width", n, l + 1);
            end
        end

        // R3: hold at start level during obeyed sync.
        @(negedge clk_in);
        sync = 1'b1; start_hi = 1'b1; ign_sync = 1'b0;
        @(negedge clk_in); @(negedge clk_in);
        chk("R3 hold high", int'(clk_out), 1);
        start_hi = 1'b0;
        @(negedge clk_in);
        chk("R3 hold low", int'(clk_out), 0);
        sync = 1'b0;

        // R5: sync disregarded while ign_sync is set.
        do_sync(4'd2, 4'd3, 4'd0, 1'b0);
        ign_sync = 1'b1;
        run_len(1'b0, n); chk("R5 low before", n, 3);
        sync = 1'b1;
        run_len(1'b1, n); chk("R5 high with sync", n, 4);
        run_len(1'b0, n); chk("R5 low with sync", n, 3);
        sync = 1'b0;

        // R7: force without ign_sync has no effect.
        do_sync(4'd1, 4'd2, 4'd0, 1'b0);
        force_lvl = 1'b1;
        run_len(1'b0, n); chk("R7 low with force", n, 2);
        run_len(1'b1, n); chk("R7 high with force", n, 3);

        // R6: force with ign_sync holds the start level.
        ign_sync = 1'b1; start_hi = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_in);
            chk("R6 forced high", int'(clk_out), 1);
        end
        start_hi = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_in);
            chk("R6 forced low", int'(clk_out), 0);
        end

        // R8: bypass passes clk_in and overrides force.
        start_hi = 1'b1; bypass = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk_in); #(CLK_PERIOD/4);
            chk("R8 bypass high", int'(clk_out), 1);
            @(negedge clk_in); #(CLK_PERIOD/4);
            chk("R8 bypass low", int'(clk_out), 0);
        end

        // R9: mid-phase change takes effect at the boundary.
        do_sync(4'd3, 4'd3, 4'd0, 1'b0);
        @(negedge clk_in); @(negedge clk_in);
        lo_cycles = 4'd0; hi_cycles = 4'd5;
        run_len(1'b0, n); chk("R9 old low completes", n, 2);
        run_len(1'b1, n); chk("R9 new high", n, 6);
        run_len(1'b0, n); chk("R9 new low", n, 1);

        // R10: counter idles during bypass and resumes.
        do_sync(4'd7, 4'd7, 4'd0, 1'b0);
        run_len(1'b0, n); chk("R10 low before", n, 8);
        @(negedge clk_in); @(negedge clk_in);
        bypass = 1'b1;
        repeat (5) @(negedge clk_in);
        bypass = 1'b0;
        #1;
        chk("R10 level kept", int'(clk_out), 1);
        run_len(1'b1, n); chk("R10 remaining high", n, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule